// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Warning Interrupt and Reset Request

This peripheral watches over system software. Once enabled, an internal count advances by one on every clock. Software must periodically restart the count through a kick register; if it fails to, the count reaches the first programmed limit and a warning interrupt is raised. If the count keeps going, it reaches the second limit and the block emits a one-cycle request for a system reset.

A status flag records that a watchdog-induced reset took place. The flag is kept in a separate power-on reset domain, so the reset it causes on the bus side does not erase it. After reboot, software can read the flag to learn why the system restarted, and then clear it.

Access is through a plain register bus. There is a write strobe, a read strobe, a byte address of word-aligned registers and 32-bit data. Reads are combinational. Typical use is to disable the block, kick it, load both limits and then enable it.

Top module: `wdog_bark_bite`

## Requirements
- R1: After the bus reset, the enable, both limit registers, `bark_irq` and `bite_req` are all 0. Every mapped register then reads 0, apart from the status flag.
- R2: The enable register is at offset 0x08, with bit 0 as the enable. Its value reads back. Writing 0 freezes the count at its current value and drops `bark_irq`. Enabling again resumes the count from where it stopped.
- R3: Writing exactly 1 to offset 0x04 does three things: it returns the count to 0, drops `bark_irq` and re-arms the reset request. It leaves the enable unchanged. Any other value written there has no effect, and the offset reads 0.
- R4: The count is 0 after the write that enables the block and rises by one per clock. `bark_irq` goes high one cycle after the count equals the warning limit (offset 0x10). For limit N, that is N+1 cycles after the enabling write. It then stays high.
- R5: `bite_req` pulses for exactly one cycle, one cycle after the count equals the reset limit (offset 0x14). For limit M, that is M+1 cycles after the enabling write. The count then stops at the limit, and no further pulse occurs until a kick.
- R6: Equal limits, including both at 0, give the warning and the reset request in the same cycle.
- R7: Bit 0 at offset 0xC becomes 1 in the same cycle as a reset request. The bus reset does not clear it. Only the power-on reset or a write with bit 0 set clears it, and a write with bit 0 clear leaves it unchanged.
- R8: A limit write above 0x10000000 stores 0x10000000. Smaller values are stored as written, and both limits read back.
- R9: Unmapped or misaligned addresses read 0, and writes to them change nothing. `rdata` is 0 while the read strobe is low.
- R10: A limit changed while counting takes effect at the next comparison. Comparison is count greater than or equal to limit. Lowering a limit below the current count therefore fires on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset; also the reset that the request drives |
| por_n | input | 1 | Active-low power-on reset for the status flag |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW | Byte address of a 32-bit register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| bark_irq | output | 1 | Warning interrupt, level |
| bite_req | output | 1 | Reset request, single-cycle pulse |

## Verification
The assertions assume the following about the inputs:
- Both resets start asserted.
- The bus strobes are synchronous, with no more than one access per cycle.
- The power-on reset is never released while the bus reset is asserted in a way that breaks causality between a reset request and the status flag.

The bench drives every access as a single-cycle strobe set up at the falling edge. It only pulses the power-on reset while the bus reset is inactive, and it never asserts both strobes at once.

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [DW-1:0] LIMIT_MAX = 32'h1000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          por_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bark_irq,
  output logic          bite_req
);

  localparam logic [AW-1:0] OFS_KICK = AW'(8'h04);
  localparam logic [AW-1:0] OFS_EN   = AW'(8'h08);
  localparam logic [AW-1:0] OFS_STAT = AW'(8'h0C);
  localparam logic [AW-1:0] OFS_WARN = AW'(8'h10);
  localparam logic [AW-1:0] OFS_RST  = AW'(8'h14);

  logic          en_q;
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] warn_lim_q;
  logic [DW-1:0] rst_lim_q;
  logic          fired_q;
  logic          warn_q;
  logic          bite_q;
  logic          sticky_q;

  logic [DW-1:0] wdata_clamped;
  assign wdata_clamped = (wdata > LIMIT_MAX) ? LIMIT_MAX : wdata;

  logic kick_w, dis_w, stat_clr_w;
  assign kick_w     = wr_en && (addr == OFS_KICK) && (wdata == DW'(1));
  assign dis_w      = wr_en && (addr == OFS_EN) && !wdata[0];
  assign stat_clr_w = wr_en && (addr == OFS_STAT) && wdata[0];

  logic warn_hit, bite_fire;
  assign warn_hit  = en_q && !kick_w && (cnt_q >= warn_lim_q);
  assign bite_fire = en_q && !kick_w && !fired_q && (cnt_q >= rst_lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      warn_lim_q <= '0;
      rst_lim_q  <= '0;
    end else if (wr_en) begin
      if (addr == OFS_EN)   en_q       <= wdata[0];
      if (addr == OFS_WARN) warn_lim_q <= wdata_clamped;
      if (addr == OFS_RST)  rst_lim_q  <= wdata_clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (kick_w) begin
      cnt_q <= '0;
    end else if (en_q && (cnt_q < rst_lim_q)) begin
      cnt_q <= cnt_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_q  <= 1'b0;
      fired_q <= 1'b0;
      bite_q  <= 1'b0;
    end else begin
      if (kick_w || dis_w) warn_q <= 1'b0;
      else if (warn_hit)   warn_q <= 1'b1;
      if (kick_w)          fired_q <= 1'b0;
      else if (bite_fire)  fired_q <= 1'b1;
      bite_q <= bite_fire;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          sticky_q <= 1'b0;
    else if (bite_fire)  sticky_q <= 1'b1;
    else if (stat_clr_w) sticky_q <= 1'b0;
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_EN:   rdata = {{(DW-1){1'b0}}, en_q};
        OFS_STAT: rdata = {{(DW-1){1'b0}}, sticky_q};
        OFS_WARN: rdata = warn_lim_q;
        OFS_RST:  rdata = rst_lim_q;
        default:  rdata = '0;
      endcase
    end
  end

  assign bark_irq = warn_q;
  assign bite_req = bite_q;

endmodule

module wdog_bark_bite_chk #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          por_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          bark_irq,
  input logic          bite_req,
  input logic          en_q,
  input logic [DW-1:0] cnt_q,
  input logic          sticky_q
);

  logic kick_seen;
  assign kick_seen = wr_en && (addr == AW'(8'h04)) && (wdata == DW'(1));

  // R5
  bite_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bite_req |=> !bite_req);

  // R7
  bite_status_chk: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    bite_req |-> sticky_q);

  // R3
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick_seen |=> (cnt_q == '0 && !bark_irq));

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !kick_seen) |=> $stable(cnt_q));

  // R2
  disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(8'h08) && !wdata[0]) |=> (!en_q && !bark_irq));

  // R4
  bark_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bark_irq) |-> $past(en_q));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == '0));

endmodule

bind wdog_bark_bite wdog_bark_bite_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_wdog_bark_bite.sv
module sim_wdog_bark_bite;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bark_irq, bite_req;

  wdog_bark_bite u0 (.clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .bark_irq(bark_irq), .bite_req(bite_req));

  always #(CLK_P/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit prev_bark = 1'b0;
  int    q_kind[$];
  int    q_cyc[$];
  string q_req[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic push(input int k, input int c, input string r);
    q_kind.push_back(k);
    q_cyc.push_back(c);
    q_req.push_back(r);
  endtask

  task automatic seen(input int k);
    n_chk++;
    if (q_kind.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event actual=kind%0d@%0d expected=none", k, cyc);
    end else begin
      int ek = q_kind.pop_front();
      int ec = q_cyc.pop_front();
      string er = q_req.pop_front();
      if (ek != k || ec != cyc) begin
        n_bad++;
        $display("FAIL %s actual=kind%0d@%0d expected=kind%0d@%0d", er, k, cyc, ek, ec);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (bark_irq && !prev_bark) seen(1);
      if (bite_req) seen(2);
    end
    prev_bark <= bark_irq;
  end

  task automatic drain(input string r);
    n_chk++;
    if (q_kind.size() != 0) begin
      n_bad++;
      $display("FAIL %s actual=%0d pending expected=0 pending", r, q_kind.size());
    end
    q_kind.delete(); q_cyc.delete(); q_req.delete();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, output int at);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 at = cyc;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic setup(input logic [31:0] warn, input logic [31:0] lim, output int e);
    int t;
    wr(8'h08, 0, t);
    wr(8'h04, 1, t);
    wr(8'h10, warn, t);
    wr(8'h14, lim, t);
    wr(8'h08, 1, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int t, e, w, c;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    chk("R1 bark", {31'b0, bark_irq}, 0);
    chk("R1 bite", {31'b0, bite_req}, 0);
    rd(8'h08, d); chk("R1 en", d, 0);
    rd(8'h10, d); chk("R1 warn", d, 0);
    rd(8'h14, d); chk("R1 lim", d, 0);
    rd(8'h0C, d); chk("R1 status", d, 0);

    // R9 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF, t);
    wr(8'h0A, 32'hFFFF_FFFF, t);
    wr(8'h11, 32'h55, t);
    rd(8'h18, d); chk("R9 unmapped read", d, 0);
    rd(8'h0A, d); chk("R9 misaligned read", d, 0);
    rd(8'h08, d); chk("R9 en untouched", d, 0);
    rd(8'h10, d); chk("R9 warn untouched", d, 0);
    @(negedge clk); chk("R9 idle rdata", rdata, 0);
    rd(8'h04, d); chk("R3 kick reads 0", d, 0);

    // R8 clamping
    wr(8'h10, 32'h2000_0000, t); rd(8'h10, d); chk("R8 warn clamp", d, 32'h1000_0000);
    wr(8'h14, 32'h0FFF_FFFF, t); rd(8'h14, d); chk("R8 lim keep", d, 32'h0FFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF, t); rd(8'h14, d); chk("R8 lim clamp", d, 32'h1000_0000);

    // R4 R5 basic run
    setup(10, 20, e);
    push(1, e + 11, "R4"); push(2, e + 21, "R5");
    repeat (40) @(negedge clk);
    drain("R5");
    chk("R4 level held", {31'b0, bark_irq}, 1);
    rd(8'h0C, d); chk("R7 status set", d, 1);

    // R7 clear semantics
    wr(8'h0C, 0, t); rd(8'h0C, d); chk("R7 write0 keeps", d, 1);
    wr(8'h0C, 1, t); rd(8'h0C, d); chk("R7 write1 clears", d, 0);

    // R3 kick
    wr(8'h04, 2, t); chk("R3 other value ignored", {31'b0, bark_irq}, 1);
    wr(8'h04, 1, e);
    chk("R3 kick drops bark", {31'b0, bark_irq}, 0);
    push(1, e + 11, "R3"); push(2, e + 21, "R3");
    rd(8'h08, d); chk("R3 en kept", d, 1);
    repeat (40) @(negedge clk);
    drain("R3");

    // R2 pause and resume
    setup(30, 60, e);
    repeat (10) @(negedge clk);
    wr(8'h08, 0, w);
    c = w - e;
    rd(8'h08, d); chk("R2 en reads 0", d, 0);
    repeat (20) @(negedge clk);
    chk("R2 no bark while off", {31'b0, bark_irq}, 0);
    wr(8'h08, 1, e);
    push(1, e + 30 - c + 1, "R2"); push(2, e + 60 - c + 1, "R2");
    repeat (80) @(negedge clk);
    drain("R2");
    wr(8'h08, 0, t);
    chk("R2 disable drops bark", {31'b0, bark_irq}, 0);

    // R6 equal limits, and both zero
    setup(15, 15, e);
    push(1, e + 16, "R6"); push(2, e + 16, "R6");
    repeat (30) @(negedge clk);
    drain("R6");
    setup(0, 0, e);
    push(1, e + 1, "R6 zero"); push(2, e + 1, "R6 zero");
    repeat (10) @(negedge clk);
    drain("R6 zero");
    wr(8'h0C, 1, t);

    // R10 limits changed mid-run
    setup(1000, 2000, e);
    repeat (20) @(negedge clk);
    wr(8'h10, 5, w);
    push(1, w + 1, "R10");
    wr(8'h14, 8, w);
    push(2, w + 1, "R10");
    repeat (20) @(negedge clk);
    drain("R10");

    // R7 survives bus reset, R1 bus reset clears the rest
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    rd(8'h0C, d); chk("R7 survives bus reset", d, 1);
    rd(8'h08, d); chk("R1 en after reset", d, 0);
    rd(8'h10, d); chk("R1 warn after reset", d, 0);
    chk("R1 bark after reset", {31'b0, bark_irq}, 0);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(8'h0C, d); chk("R7 por clears", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule